// File: doc/BRIEF.md
# Versioned Lock Table with Commit-Time Read Validation

This block keeps the concurrency metadata for a small hardware transaction engine in which writers lock and readers are checked by version. Each address maps to one metadata entry. An entry is either free, when it holds a version number, or locked, when it holds the id of the owning transaction context. A context issues begin, read, write and commit requests. A read records the entry and the version it saw, and it takes no lock. A write locks the entry, saves the old memory word in an undo log and then updates memory in place. A commit checks every recorded read. If all of them are still valid, the commit unlocks the written entries with their versions stepped up. Otherwise the transaction aborts: the undo log is played back into memory, the entries are unlocked with their versions unchanged, and the abort is reported.

The backing memory lies outside the block. The block reads memory through a combinational port (`mem_raddr`/`mem_rdata`) and writes it through a registered port (`mem_we`/`mem_waddr`/`mem_wdata`). With the default parameters there are 2 contexts and 16 entries, the entry index is the low 4 address bits, each log has 8 slots and versions are 4 bits wide.

The controller has three states. In IDLE it accepts one request per cycle and answers it in the next cycle. IDLE moves to UNDO when an accepted request has to abort. UNDO writes back one undo slot per cycle, newest first, and moves to RELEASE once the log is empty. RELEASE unlocks the aborted context's entries, reports the abort and returns to IDLE. `req_ready` is high only in IDLE.

Top module: `vlt_table`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_we`=0. Every entry is free at version 0.
- R2: Request codes on `req_op` are 0 begin, 1 read, 2 write and 3 commit. Response codes on `rsp_status` are 0 ok, 1 committed and 2 aborted. A read answers ok in the next cycle with the memory word at `req_addr`. It takes no lock, so another context can still write that entry.
- R3: A write locks the entry (index `req_addr[3:0]`) and writes `req_wdata` to memory in place. A write that finds the entry locked by the other context aborts the requester immediately.
- R4: A commit aborts if any entry in the read log has changed version since it was read, or if it is locked by another context.
- R5: A read followed by the same context's write to the same entry validates, and so does a write followed by its own read. That read returns the value the context wrote.
- R6: A successful commit answers committed, writes no memory in that cycle, and unlocks every owned entry with its version incremented. A reader that read the old version then fails its own commit.
- R7: On abort the undo log is written back newest first, one slot per cycle, so that the oldest saved value is the one left in memory. The entries are then unlocked with their versions unchanged. `rsp_valid` stays low while `req_ready` is low, and the abort is reported in the cycle `req_ready` returns high.
- R8: A ninth read, or a ninth write that needs an undo slot or a new lock, aborts the transaction.
- R9: A commit that moves an entry's version from its maximum value to 0 dooms every other context that holds that entry in its read log, and that context's next commit aborts. A begin clears the doom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_op | input | 2 | 0 begin, 1 read, 2 write, 3 commit |
| req_ctx | input | CW | Requesting context |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_ctx | output | CW | Context answered |
| rsp_status | output | 2 | 0 ok, 1 committed, 2 aborted |
| rsp_data | output | DW | Read data |
| mem_raddr | output | AW | Memory read address (follows `req_addr`) |
| mem_rdata | input | DW | Memory read data, combinational |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
Most wrong internal state stays hidden until a commit. A stale version, an entry left locked or a missing doom flag appears only as a wrong committed/aborted answer, one cycle after the commit request. A wrong undo order or undo count appears in backing memory only after the abort has been reported, so the bench reads memory once the abort comes back. Wrap-around aliasing takes sixteen commits on one entry before it shows, so the bench runs that whole sequence while an old reader stays open.

// File: rtl/vlt_pkg.sv
`timescale 1ns/1ps
package vlt_pkg;
    typedef enum logic [1:0] {
        OP_BEGIN  = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_COMMIT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RS_OK     = 2'd0,
        RS_COMMIT = 2'd1,
        RS_ABORT  = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UNDO,
        ST_RELEASE
    } st_e;
endpackage

// File: rtl/vlt_validator.sv
`timescale 1ns/1ps
// Checks one context's read log against the live metadata table.
module vlt_validator #(
    parameter int NENT = 16,
    parameter int LOGD = 8,
    parameter int VW   = 4,
    parameter int CW   = 1,
    parameter int IW   = 4,
    parameter int LW   = 4
) (
    input  logic [CW-1:0] ctx_id,
    input  logic          own    [NENT],
    input  logic [VW-1:0] val    [NENT],
    input  logic [LW-1:0] rl_cnt,
    input  logic [IW-1:0] rl_idx [LOGD],
    input  logic [VW-1:0] rl_ver [LOGD],
    input  logic          rl_bad [LOGD],
    input  logic [LW-1:0] wl_cnt,
    input  logic [IW-1:0] wl_idx [LOGD],
    input  logic [VW-1:0] wl_ver [LOGD],
    output logic          all_ok
);
    logic [LOGD-1:0] slot_ok;

    for (genvar i = 0; i < LOGD; i++) begin : g_slot
        logic [VW-1:0] held_ver;
        always_comb begin
            held_ver = '0;
            for (int j = 0; j < LOGD; j++)
                if (LW'(j) < wl_cnt && wl_idx[j] == rl_idx[i])
                    held_ver = wl_ver[j];
        end
        assign slot_ok[i] = (LW'(i) >= rl_cnt) ? 1'b1 :
                            rl_bad[i]          ? 1'b0 :
                            own[rl_idx[i]]     ? ((val[rl_idx[i]] == VW'(ctx_id)) &&
                                                  (held_ver == rl_ver[i])) :
                                                 (val[rl_idx[i]] == rl_ver[i]);
    end

    assign all_ok = &slot_ok;
endmodule

// File: rtl/vlt_table.sv
`timescale 1ns/1ps
module vlt_table
    import vlt_pkg::*;
#(
    parameter int NCTX = 2,
    parameter int NENT = 16,
    parameter int LOGD = 8,
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int VW   = 4,
    localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [CW-1:0] req_ctx,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [CW-1:0] rsp_ctx,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);
    localparam int IW = $clog2(NENT);
    localparam int SW = $clog2(LOGD);
    localparam int LW = SW + 1;
    localparam logic [VW-1:0] VMAX = '1;
    localparam logic [LW-1:0] LFULL = LW'(LOGD);

    st_e           state_q, state_d;
    logic [CW-1:0] ab_ctx_q;

    logic          own_q [NENT];
    logic [VW-1:0] val_q [NENT];

    logic [IW-1:0] rl_idx_q  [NCTX][LOGD];
    logic [VW-1:0] rl_ver_q  [NCTX][LOGD];
    logic          rl_bad_q  [NCTX][LOGD];
    logic [LW-1:0] rl_cnt_q  [NCTX];
    logic [IW-1:0] wl_idx_q  [NCTX][LOGD];
    logic [VW-1:0] wl_ver_q  [NCTX][LOGD];
    logic [LW-1:0] wl_cnt_q  [NCTX];
    logic [AW-1:0] ul_addr_q [NCTX][LOGD];
    logic [DW-1:0] ul_old_q  [NCTX][LOGD];
    logic [LW-1:0] ul_cnt_q  [NCTX];
    logic          doom_q    [NCTX];
    logic          val_ok    [NCTX];

    // one validator per context, picked by the requester
    for (genvar c = 0; c < NCTX; c++) begin : g_val
        vlt_validator #(.NENT(NENT), .LOGD(LOGD), .VW(VW), .CW(CW), .IW(IW), .LW(LW)) u_val (
            .ctx_id (CW'(c)),
            .own    (own_q),
            .val    (val_q),
            .rl_cnt (rl_cnt_q[c]),
            .rl_idx (rl_idx_q[c]),
            .rl_ver (rl_ver_q[c]),
            .rl_bad (rl_bad_q[c]),
            .wl_cnt (wl_cnt_q[c]),
            .wl_idx (wl_idx_q[c]),
            .wl_ver (wl_ver_q[c]),
            .all_ok (val_ok[c])
        );
    end

    logic [IW-1:0] ridx;
    logic          hit_own, hit_other, rd_ok, wr_ok, cm_ok, accept, go_abort;
    logic [VW-1:0] self_ver;
    logic [LW-1:0] ul_top;

    assign mem_raddr = req_addr;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign ridx      = req_addr[IW-1:0];
    assign hit_own   = own_q[ridx] && (val_q[ridx] == VW'(req_ctx));
    assign hit_other = own_q[ridx] && !hit_own;
    assign rd_ok     = rl_cnt_q[req_ctx] < LFULL;
    assign wr_ok     = !hit_other && (ul_cnt_q[req_ctx] < LFULL) &&
                       (hit_own || wl_cnt_q[req_ctx] < LFULL);
    assign cm_ok     = !doom_q[req_ctx] && val_ok[req_ctx];
    assign go_abort  = accept && ((req_op == OP_READ   && !rd_ok) ||
                                  (req_op == OP_WRITE  && !wr_ok) ||
                                  (req_op == OP_COMMIT && !cm_ok));
    assign ul_top    = ul_cnt_q[ab_ctx_q] - 1'b1;

    // version saved when this context locked the entry
    always_comb begin
        self_ver = '0;
        for (int i = 0; i < LOGD; i++)
            if (LW'(i) < wl_cnt_q[req_ctx] && wl_idx_q[req_ctx][i] == ridx)
                self_ver = wl_ver_q[req_ctx][i];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go_abort) state_d = ST_UNDO;
            ST_UNDO:    if (ul_cnt_q[ab_ctx_q] == '0) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // metadata and logs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                own_q[e] <= 1'b0;
                val_q[e] <= '0;
            end
            for (int c = 0; c < NCTX; c++) begin
                rl_cnt_q[c] <= '0;
                wl_cnt_q[c] <= '0;
                ul_cnt_q[c] <= '0;
                doom_q[c]   <= 1'b0;
            end
            ab_ctx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    ab_ctx_q <= req_ctx;
                    unique case (req_op)
                        OP_BEGIN: begin
                            rl_cnt_q[req_ctx] <= '0;
                            wl_cnt_q[req_ctx] <= '0;
                            ul_cnt_q[req_ctx] <= '0;
                            doom_q[req_ctx]   <= 1'b0;
                        end
                        OP_READ: if (rd_ok) begin
                            rl_idx_q[req_ctx][rl_cnt_q[req_ctx][SW-1:0]] <= ridx;
                            rl_ver_q[req_ctx][rl_cnt_q[req_ctx][SW-1:0]] <= hit_own ? self_ver : val_q[ridx];
                            rl_bad_q[req_ctx][rl_cnt_q[req_ctx][SW-1:0]] <= hit_other;
                            rl_cnt_q[req_ctx] <= rl_cnt_q[req_ctx] + 1'b1;
                        end
                        OP_WRITE: if (wr_ok) begin
                            if (!hit_own) begin
                                own_q[ridx] <= 1'b1;
                                val_q[ridx] <= VW'(req_ctx);
                                wl_idx_q[req_ctx][wl_cnt_q[req_ctx][SW-1:0]] <= ridx;
                                wl_ver_q[req_ctx][wl_cnt_q[req_ctx][SW-1:0]] <= val_q[ridx];
                                wl_cnt_q[req_ctx] <= wl_cnt_q[req_ctx] + 1'b1;
                            end
                            ul_addr_q[req_ctx][ul_cnt_q[req_ctx][SW-1:0]] <= req_addr;
                            ul_old_q[req_ctx][ul_cnt_q[req_ctx][SW-1:0]]  <= mem_rdata;
                            ul_cnt_q[req_ctx] <= ul_cnt_q[req_ctx] + 1'b1;
                        end
                        OP_COMMIT: if (cm_ok) begin
                            for (int i = 0; i < LOGD; i++) begin
                                if (LW'(i) < wl_cnt_q[req_ctx]) begin
                                    own_q[wl_idx_q[req_ctx][i]] <= 1'b0;
                                    val_q[wl_idx_q[req_ctx][i]] <= wl_ver_q[req_ctx][i] + 1'b1;
                                    if (wl_ver_q[req_ctx][i] == VMAX)
                                        for (int c = 0; c < NCTX; c++)
                                            for (int k = 0; k < LOGD; k++)
                                                if (c != int'(req_ctx) && LW'(k) < rl_cnt_q[c] &&
                                                    rl_idx_q[c][k] == wl_idx_q[req_ctx][i])
                                                    doom_q[c] <= 1'b1;
                                end
                            end
                            rl_cnt_q[req_ctx] <= '0;
                            wl_cnt_q[req_ctx] <= '0;
                            ul_cnt_q[req_ctx] <= '0;
                        end
                        default: ;
                    endcase
                end
                ST_UNDO: if (ul_cnt_q[ab_ctx_q] != '0) ul_cnt_q[ab_ctx_q] <= ul_top;
                ST_RELEASE: begin
                    for (int i = 0; i < LOGD; i++) begin
                        if (LW'(i) < wl_cnt_q[ab_ctx_q]) begin
                            own_q[wl_idx_q[ab_ctx_q][i]] <= 1'b0;
                            val_q[wl_idx_q[ab_ctx_q][i]] <= wl_ver_q[ab_ctx_q][i];
                        end
                    end
                    rl_cnt_q[ab_ctx_q] <= '0;
                    wl_cnt_q[ab_ctx_q] <= '0;
                    doom_q[ab_ctx_q]   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_ctx    <= '0;
            rsp_status <= RS_OK;
            rsp_data   <= '0;
            mem_we     <= 1'b0;
            mem_waddr  <= '0;
            mem_wdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            mem_we    <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept && !go_abort) begin
                    rsp_valid  <= 1'b1;
                    rsp_ctx    <= req_ctx;
                    rsp_status <= (req_op == OP_COMMIT) ? RS_COMMIT : RS_OK;
                    rsp_data   <= mem_rdata;
                    if (req_op == OP_WRITE) begin
                        mem_we    <= 1'b1;
                        mem_waddr <= req_addr;
                        mem_wdata <= req_wdata;
                    end
                end
                ST_UNDO: if (ul_cnt_q[ab_ctx_q] != '0) begin
                    mem_we    <= 1'b1;
                    mem_waddr <= ul_addr_q[ab_ctx_q][ul_top[SW-1:0]];
                    mem_wdata <= ul_old_q[ab_ctx_q][ul_top[SW-1:0]];
                end
                ST_RELEASE: begin
                    rsp_valid  <= 1'b1;
                    rsp_ctx    <= ab_ctx_q;
                    rsp_status <= RS_ABORT;
                    rsp_data   <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vlt_checker.sv
`timescale 1ns/1ps
module vlt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [1:0] rsp_status,
    input logic       mem_we
);
    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || !req_ready));

    a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    a_r7_quiet_rollback: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rsp_valid);

    a_r7_abort_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (rsp_valid && rsp_status == 2'd2));

    a_r6_commit_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1) |-> !mem_we);
endmodule

bind vlt_table vlt_checker u_vlt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .mem_we     (mem_we)
);

// File: tb/test_vlt_table.sv
`timescale 1ns/1ps
module test_vlt_table;
    import vlt_pkg::*;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [CW-1:0] req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [CW-1:0] rsp_ctx;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_raddr, mem_waddr;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic          mem_we;

    vlt_table i_vlt_table (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_ctx(req_ctx), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ctx(rsp_ctx), .rsp_status(rsp_status), .rsp_data(rsp_data),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    logic [DW-1:0] mem [256];
    always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;
    assign mem_rdata = mem[mem_raddr];

    function automatic int initv(int a);
        return (a * 3 + 1) & 16'hffff;
    endfunction

    typedef struct {
        logic [CW-1:0] ctx;
        logic [1:0]    st;
        logic [DW-1:0] data;
        bit            chk;
        string         tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int n_rsp = 0;

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input int a, input int exp, input string tag);
        @(negedge clk);
        chk(mem[a] === DW'(exp), tag, int'(mem[a]), exp);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected response: actual ctx=%0d st=%0d expected none", rsp_ctx, rsp_status);
            end else begin
                e = q.pop_front();
                if (rsp_ctx !== e.ctx || rsp_status !== e.st || (e.chk && rsp_data !== e.data)) begin
                    n_fail++;
                    $display("FAIL %s: actual ctx=%0d st=%0d data=%0h expected ctx=%0d st=%0d data=%0h",
                             e.tag, rsp_ctx, rsp_status, rsp_data, e.ctx, e.st, e.data);
                end
            end
            n_rsp++;
        end
    end

    // driver: push expectation, issue one request, wait for its answer
    task automatic op(input int ctx, input logic [1:0] o, input int addr, input int wd,
                      input logic [1:0] st, input int data, input bit dchk, input string tag);
        exp_t e;
        int want;
        e.ctx = CW'(ctx); e.st = st; e.data = DW'(data); e.chk = dchk; e.tag = tag;
        q.push_back(e);
        want = n_rsp + 1;
        @(negedge clk);
        req_valid = 1'b1; req_ctx = CW'(ctx); req_op = o;
        req_addr = AW'(addr); req_wdata = DW'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        wait (n_rsp >= want);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected all requirements R1..R9 done");
        finish_up();
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = DW'(initv(a));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
        chk(mem_we === 1'b0, "R1 no write in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 invisible read, R6 bump invalidates reader, R4 changed version
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R2 begin");
        op(0, OP_READ, 8'h05, 0, RS_OK, initv(5), 1, "R2 read data");
        op(1, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R2 begin other");
        op(1, OP_WRITE, 8'h05, 16'haaaa, RS_OK, 0, 0, "R2 read takes no lock");
        chk_mem(8'h05, 16'haaaa, "R3 write in place");
        op(1, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R6 commit");
        op(0, OP_COMMIT, 0, 0, RS_ABORT, 0, 0, "R4 version changed");

        // R3 conflict aborts requester, R5 write then read
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R3 begin");
        op(0, OP_WRITE, 8'h13, 16'h1111, RS_OK, 0, 0, "R3 lock");
        op(1, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R3 begin other");
        op(1, OP_WRITE, 8'h23, 16'h9999, RS_ABORT, 0, 0, "R3 locked by other");
        op(0, OP_READ, 8'h13, 0, RS_OK, 16'h1111, 1, "R5 read own write");
        op(0, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R5 write then read commit");
        chk_mem(8'h23, initv(8'h23), "R3 aborted write left memory");

        // R5 read then write
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R5 begin");
        op(0, OP_READ, 8'h07, 0, RS_OK, initv(7), 1, "R5 read");
        op(0, OP_WRITE, 8'h07, 16'h7777, RS_OK, 0, 0, "R5 write");
        op(0, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R5 read then write commit");

        // R4 owned by other at commit
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R4 begin");
        op(0, OP_READ, 8'h08, 0, RS_OK, initv(8), 1, "R4 read");
        op(1, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R4 begin other");
        op(1, OP_WRITE, 8'h18, 16'h5555, RS_OK, 0, 0, "R4 other locks");
        op(0, OP_COMMIT, 0, 0, RS_ABORT, 0, 0, "R4 locked by other");
        op(1, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R6 other commits");

        // R7 reverse undo, version unchanged after abort
        op(1, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R7 begin reader");
        op(1, OP_READ, 8'h0a, 0, RS_OK, initv(8'h0a), 1, "R7 reader read");
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R7 begin writer");
        op(0, OP_WRITE, 8'h0a, 16'h1000, RS_OK, 0, 0, "R7 write 1");
        op(0, OP_WRITE, 8'h0a, 16'h2000, RS_OK, 0, 0, "R7 write 2");
        op(0, OP_READ, 8'h0a, 0, RS_OK, 16'h2000, 1, "R3 in-place value");
        op(0, OP_WRITE, 8'h1b, 16'h3000, RS_OK, 0, 0, "R7 write 3");
        op(1, OP_WRITE, 8'h0c, 16'h4444, RS_OK, 0, 0, "R7 reader locks C");
        op(0, OP_WRITE, 8'h1c, 16'h6666, RS_ABORT, 0, 0, "R7 forced abort");
        chk_mem(8'h0a, initv(8'h0a), "R7 oldest value restored");
        chk_mem(8'h1b, initv(8'h1b), "R7 second entry restored");
        chk_mem(8'h1c, initv(8'h1c), "R7 conflicting write not stored");
        op(1, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R7 version unchanged by abort");
        chk_mem(8'h0c, 16'h4444, "R6 committed data kept");

        // R8 log overflow
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R8 begin reads");
        for (int k = 0; k < 8; k++)
            op(0, OP_READ, 8'h30 + k, 0, RS_OK, initv(8'h30 + k), 1, "R8 read within log");
        op(0, OP_READ, 8'h38, 0, RS_ABORT, 0, 0, "R8 ninth read");
        op(1, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R8 begin writes");
        for (int k = 0; k < 8; k++)
            op(1, OP_WRITE, 8'h40 + k, 16'hb000 + k, RS_OK, 0, 0, "R8 write within log");
        op(1, OP_WRITE, 8'h48, 16'hbbbb, RS_ABORT, 0, 0, "R8 ninth write");
        chk_mem(8'h40, initv(8'h40), "R8 first write undone");
        chk_mem(8'h47, initv(8'h47), "R8 last write undone");
        chk_mem(8'h48, initv(8'h48), "R8 ninth write not stored");

        // R9 version wrap dooms old reader
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R9 begin reader");
        op(0, OP_READ, 8'h0e, 0, RS_OK, initv(8'h0e), 1, "R9 read at version 0");
        for (int k = 0; k < 16; k++) begin
            op(1, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R9 begin writer");
            op(1, OP_WRITE, 8'h2e, k, RS_OK, 0, 0, "R9 write");
            op(1, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R9 writer commit");
        end
        op(0, OP_COMMIT, 0, 0, RS_ABORT, 0, 0, "R9 wrapped version aborts reader");
        op(0, OP_BEGIN, 0, 0, RS_OK, 0, 0, "R9 begin clears doom");
        op(0, OP_READ, 8'h0e, 0, RS_OK, initv(8'h0e), 1, "R9 read after wrap");
        op(0, OP_COMMIT, 0, 0, RS_COMMIT, 0, 0, "R9 fresh reader commits");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R2 all responses seen", q.size(), 0);
        finish_up();
    end
endmodule